// File: doc/BRIEF.md
# Round-Robin Channel Sampler with Averaging

This block visits two or four current-sense channels in a fixed rotation. For each channel it asks an external converter for one 8-bit reading per time slot, using a one-cycle request and a one-cycle valid strobe. Each channel has its own accumulator, which sums a power-of-two number of readings. When the window is full, the block publishes the mean to that channel's result register and pulses an update flag. Every accepted reading is also passed on unaveraged, tagged with its channel, so that threshold logic downstream can compare raw samples.

The window length comes from a 3-bit averaging code held in a small configuration register. A new code restarts every accumulator, and results already published stay visible until fresh means replace them. The slot length is a parameter: the default gives each of four channels a 1 kHz sample rate from a 100 MHz clock, and short slots can be used for simulation. The slot length must be at least two clocks.

Top module: `rr_avg_sampler`

## Requirements
- R1: After reset every result reads 8'h00, the averaging code reads 3'b100 (16 samples), and no raw strobe or update flag is asserted.
- R2: One converter request is issued every SLOT_CLKS clocks, in the order 0, 1, ..., NUM_CH-1, and then back to 0. The channel index on conv_ch_o is plain binary.
- R3: A valid strobe that answers an open request appears one clock later on raw_valid_o, together with the requested channel on raw_ch_o and the unchanged reading on raw_data_o.
- R4: After 2^N accepted readings of a channel, that channel's result becomes floor(sum/2^N). It is published one clock after the last reading, with a one-cycle pulse on bit c of result_upd_o.
- R5: A write on avg_we_i loads avg_code_i into the code register at the next edge. Codes 0 to 7 select windows of 1, 2, 4, 8, 16, 32, 64 and 128 readings.
- R6: A result register changes only in a cycle where its update flag pulses. Between publications it holds the previous mean.
- R7: Writing a code that differs from the current one discards every partial sum. The next mean of each channel covers only readings taken after the write.
- R8: With NUM_CH=2, requests name only channels 0 and 1, and the results for the third and fourth channels always read 8'h00.
- R9: A valid strobe with no open request is ignored. It raises no raw strobe and does not change any accumulator or result.
- R10: Writing the code that is already held does not restart the accumulators.
- R11: A full 128-reading window of 8'hFF-range values averages without overflow. For example, 128 readings of 255 give 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| avg_we_i | input | 1 | Write strobe for the averaging code |
| avg_code_i | input | 3 | New averaging code N (window 2^N) |
| avg_code_o | output | 3 | Averaging code currently held |
| conv_req_o | output | 1 | One-cycle conversion request |
| conv_ch_o | output | 2 | Channel being sampled in this slot |
| conv_valid_i | input | 1 | Converter reading strobe |
| conv_data_i | input | 8 | Converter reading |
| raw_valid_o | output | 1 | Raw sample strobe to threshold logic |
| raw_ch_o | output | 2 | Channel of the raw sample |
| raw_data_o | output | 8 | Raw sample value |
| result_o | output | 32 | Four 8-bit means, channel c in bits [8c+7:8c] |
| result_upd_o | output | 4 | One-cycle publication pulse per channel |

## Verification
The bench builds two copies with an 8-clock slot. One has four channels, and it runs all eight averaging codes end to end, including the 128-reading window, in a few thousand cycles. The other has two channels, so the unused result slots and the shorter rotation can be observed side by side. The short slot also leaves room after each 2-cycle converter answer to place a stray strobe in the request cycle, where no request is open yet.

// File: rtl/rr_sampler_pkg.sv
package rr_sampler_pkg;
  localparam int SMP_W   = 8;
  localparam int CODE_W  = 3;
  localparam int MAX_CH  = 4;
  localparam int CH_W    = $clog2(MAX_CH);
  localparam int MAX_LOG = (1 << CODE_W) - 1;
  localparam int CNT_W   = MAX_LOG;
  localparam int ACC_W   = SMP_W + MAX_LOG;
  localparam logic [CODE_W-1:0] AVG_RST = 3'b100;

  typedef logic [SMP_W-1:0] smp_t;
  typedef logic [CH_W-1:0]  ch_t;

  typedef struct packed {
    logic vld;
    ch_t  ch;
    smp_t data;
  } raw_beat_t;

  function automatic logic [CNT_W-1:0] last_idx(input logic [CODE_W-1:0] code);
    logic [CNT_W:0] span;
    span = (CNT_W+1)'(1) << code;
    return CNT_W'(span - 1'b1);
  endfunction
endpackage

// File: rtl/rr_avg_cfg.sv
module rr_avg_cfg
  import rr_sampler_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic              restart_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= AVG_RST;
    else if (we_i) code_q <= wdata_i;
  end

  // only a real change of window restarts the sums
  assign restart_o = we_i && (wdata_i != code_q);
  assign code_o    = code_q;
endmodule

// File: rtl/rr_slot_seq.sv
module rr_slot_seq
  import rr_sampler_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int SLOT_CLKS = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic req_o,
  output ch_t  ch_o,
  output logic accept_o
);
  localparam int SLOT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CLKS - 1);
  localparam ch_t CH_LAST = CH_W'(NUM_CH - 1);

  logic [SLOT_W-1:0] slot_q;
  ch_t               ch_q;
  logic              pend_q;
  logic              slot_end;

  assign slot_end = (slot_q == SLOT_LAST);
  assign req_o    = (slot_q == '0);
  assign accept_o = valid_i && pend_q;
  assign ch_o     = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      ch_q   <= '0;
    end else if (slot_end) begin
      slot_q <= '0;
      ch_q   <= (ch_q == CH_LAST) ? '0 : ch_q + 1'b1;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  // a request stays open until answered or the slot closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pend_q <= 1'b0;
    else if (req_o)                 pend_q <= 1'b1;
    else if (accept_o || slot_end)  pend_q <= 1'b0;
  end
endmodule

// File: rtl/rr_chan_avg.sv
module rr_chan_avg
  import rr_sampler_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  smp_t              smp_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              restart_i,
  output smp_t              res_o,
  output logic              upd_o
);
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  smp_t             res_q;
  logic             upd_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] mean;
  logic             last;

  assign sum  = acc_q + ACC_W'(smp_i);
  assign mean = sum >> code_i;
  assign last = (cnt_q == last_idx(code_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      res_q <= '0;
      upd_q <= 1'b0;
    end else if (restart_i) begin
      acc_q <= '0;
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else if (smp_vld_i) begin
      if (last) begin
        res_q <= SMP_W'(mean);
        acc_q <= '0;
        cnt_q <= '0;
        upd_q <= 1'b1;
      end else begin
        acc_q <= sum;
        cnt_q <= cnt_q + 1'b1;
        upd_q <= 1'b0;
      end
    end else begin
      upd_q <= 1'b0;
    end
  end

  assign res_o = res_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/rr_raw_tap.sv
module rr_raw_tap
  import rr_sampler_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      accept_i,
  input  ch_t       ch_i,
  input  smp_t      data_i,
  output raw_beat_t beat_o
);
  raw_beat_t beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
    end else begin
      beat_q.vld <= accept_i;
      if (accept_i) begin
        beat_q.ch   <= ch_i;
        beat_q.data <= data_i;
      end
    end
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/rr_avg_sampler.sv
module rr_avg_sampler
  import rr_sampler_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int SLOT_CLKS = 25000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     avg_we_i,
  input  logic [CODE_W-1:0]        avg_code_i,
  output logic [CODE_W-1:0]        avg_code_o,
  output logic                     conv_req_o,
  output logic [CH_W-1:0]          conv_ch_o,
  input  logic                     conv_valid_i,
  input  logic [SMP_W-1:0]         conv_data_i,
  output logic                     raw_valid_o,
  output logic [CH_W-1:0]          raw_ch_o,
  output logic [SMP_W-1:0]         raw_data_o,
  output logic [MAX_CH*SMP_W-1:0]  result_o,
  output logic [MAX_CH-1:0]        result_upd_o
);
  logic [CODE_W-1:0] code;
  logic              restart;
  logic              accept;
  ch_t               cur_ch;
  raw_beat_t         beat;

  rr_avg_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (avg_we_i),
    .wdata_i   (avg_code_i),
    .code_o    (code),
    .restart_o (restart)
  );

  rr_slot_seq #(.NUM_CH(NUM_CH), .SLOT_CLKS(SLOT_CLKS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (conv_valid_i),
    .req_o    (conv_req_o),
    .ch_o     (cur_ch),
    .accept_o (accept)
  );

  rr_raw_tap u_tap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .ch_i     (cur_ch),
    .data_i   (conv_data_i),
    .beat_o   (beat)
  );

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    if (c < NUM_CH) begin : g_live
      rr_chan_avg u_avg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .smp_vld_i (accept && (cur_ch == CH_W'(c))),
        .smp_i     (conv_data_i),
        .code_i    (code),
        .restart_i (restart),
        .res_o     (result_o[c*SMP_W +: SMP_W]),
        .upd_o     (result_upd_o[c])
      );
    end else begin : g_absent
      assign result_o[c*SMP_W +: SMP_W] = '0;
      assign result_upd_o[c]            = 1'b0;
    end
  end

  assign avg_code_o  = code;
  assign conv_ch_o   = cur_ch;
  assign raw_valid_o = beat.vld;
  assign raw_ch_o    = beat.ch;
  assign raw_data_o  = beat.data;
endmodule

// File: rtl/rr_sampler_chk.sv
module rr_sampler_chk
  import rr_sampler_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int SLOT_CLKS = 25000
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    avg_we_i,
  input logic [CODE_W-1:0]       avg_code_i,
  input logic [CODE_W-1:0]       avg_code_o,
  input logic                    conv_req_o,
  input logic [CH_W-1:0]         conv_ch_o,
  input logic                    conv_valid_i,
  input logic [SMP_W-1:0]        conv_data_i,
  input logic                    raw_valid_o,
  input logic [CH_W-1:0]         raw_ch_o,
  input logic [SMP_W-1:0]        raw_data_o,
  input logic [MAX_CH*SMP_W-1:0] result_o,
  input logic [MAX_CH-1:0]       result_upd_o
);
  // R2, R8
  a_r2_ch_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> (int'(conv_ch_o) < NUM_CH));

  if (SLOT_CLKS > 1) begin : g_spacing
    a_r2_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_req_o |=> !conv_req_o);
  end

  a_r3_raw_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_valid_o |-> ($past(conv_valid_i) && (raw_data_o == $past(conv_data_i))));

  a_r4_upd_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(result_upd_o));

  a_r4_upd_with_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_upd_o != '0) |-> (raw_valid_o && result_upd_o[raw_ch_o]));

  a_r5_code_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_we_i |=> (avg_code_o == $past(avg_code_i)));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o != $past(result_o)) |-> (result_upd_o != '0));

  a_r7_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avg_we_i && (avg_code_i != avg_code_o)) |=> (result_upd_o == '0));
endmodule

bind rr_avg_sampler rr_sampler_chk #(.NUM_CH(NUM_CH), .SLOT_CLKS(SLOT_CLKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .avg_we_i     (avg_we_i),
  .avg_code_i   (avg_code_i),
  .avg_code_o   (avg_code_o),
  .conv_req_o   (conv_req_o),
  .conv_ch_o    (conv_ch_o),
  .conv_valid_i (conv_valid_i),
  .conv_data_i  (conv_data_i),
  .raw_valid_o  (raw_valid_o),
  .raw_ch_o     (raw_ch_o),
  .raw_data_o   (raw_data_o),
  .result_o     (result_o),
  .result_upd_o (result_upd_o)
);

// File: tb/rr_avg_sampler_test.sv
module rr_avg_sampler_test;
  localparam int SLOT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // four-channel copy
  logic       avg_we = 1'b0;
  logic [2:0] avg_wdata = '0;
  logic [2:0] avg_code;
  logic       conv_req;
  logic [1:0] conv_ch;
  logic       conv_valid;
  logic [7:0] conv_data;
  logic       raw_valid;
  logic [1:0] raw_ch;
  logic [7:0] raw_data;
  logic [31:0] result;
  logic [3:0] upd;

  logic       resp_valid = 1'b0;
  logic [7:0] resp_data = '0;
  logic       spur_valid = 1'b0;
  logic [7:0] spur_data = '0;
  assign conv_valid = resp_valid | spur_valid;
  assign conv_data  = spur_valid ? spur_data : resp_data;

  rr_avg_sampler #(.NUM_CH(4), .SLOT_CLKS(SLOT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .avg_we_i(avg_we), .avg_code_i(avg_wdata),
    .avg_code_o(avg_code), .conv_req_o(conv_req), .conv_ch_o(conv_ch),
    .conv_valid_i(conv_valid), .conv_data_i(conv_data), .raw_valid_o(raw_valid),
    .raw_ch_o(raw_ch), .raw_data_o(raw_data), .result_o(result), .result_upd_o(upd)
  );

  // two-channel copy
  logic [2:0] d_code;
  logic       d_req;
  logic [1:0] d_ch;
  logic       d_valid = 1'b0;
  logic [7:0] d_data = '0;
  logic       d_raw_valid;
  logic [1:0] d_raw_ch;
  logic [7:0] d_raw_data;
  logic [31:0] d_result;
  logic [3:0] d_upd;

  rr_avg_sampler #(.NUM_CH(2), .SLOT_CLKS(SLOT)) uut_dual (
    .clk_i(clk), .rst_ni(rst_n), .avg_we_i(1'b0), .avg_code_i(3'd0),
    .avg_code_o(d_code), .conv_req_o(d_req), .conv_ch_o(d_ch),
    .conv_valid_i(d_valid), .conv_data_i(d_data), .raw_valid_o(d_raw_valid),
    .raw_ch_o(d_raw_ch), .raw_data_o(d_raw_data), .result_o(d_result), .result_upd_o(d_upd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // stimulus {code, even reading, odd reading, expected mean of channel 0}
  localparam logic [31:0] VEC [0:7] = '{
    {8'd0, 8'd37,  8'd37,  8'd37},
    {8'd1, 8'd10,  8'd13,  8'd11},
    {8'd2, 8'd200, 8'd201, 8'd200},
    {8'd3, 8'd0,   8'd251, 8'd125},
    {8'd4, 8'd100, 8'd100, 8'd100},
    {8'd5, 8'd250, 8'd251, 8'd250},
    {8'd6, 8'd1,   8'd2,   8'd1},
    {8'd7, 8'd252, 8'd252, 8'd252}
  };

  // converter model: answers a request two clocks later
  logic resp_en = 1'b0;
  int   k [4] = '{0, 0, 0, 0};
  int   plim = 0;
  int   pa = 0;
  int   pb = 0;

  initial begin
    int cnt = 0;
    int pdata = 0;
    int pch = 0;
    bit prev = 0;
    int cdata = 0;
    int cch = 0;
    int last_cyc = -1;
    int last_ch = 0;
    forever begin
      @(negedge clk);
      if (prev) begin
        chk("R3 raw_valid", int'(raw_valid), 1);
        chk("R3 raw_ch", int'(raw_ch), cch);
        chk("R3 raw_data", int'(raw_data), cdata);
      end
      prev = 0;
      resp_valid = 1'b0;
      if (cnt == 1) begin
        resp_valid = 1'b1;
        resp_data  = 8'(pdata);
        prev = 1; cdata = pdata; cch = pch;
      end
      if (cnt != 0) cnt--;
      if (rst_n && conv_req) begin
        if (last_cyc >= 0) begin
          chk("R2 order", int'(conv_ch), (last_ch + 1) % 4);
          chk("R2 slot", cyc - last_cyc, SLOT);
        end
        last_cyc = cyc;
        last_ch = int'(conv_ch);
        if (resp_en && k[conv_ch] < plim) begin
          pch = int'(conv_ch);
          pdata = ((k[pch] % 2) ? pb : pa) + pch;
          k[pch]++;
          cnt = 2;
        end
      end
    end
  end

  // responder for the two-channel copy
  initial begin
    int dc = 0;
    int dch = 0;
    forever begin
      @(negedge clk);
      d_valid = 1'b0;
      if (dc == 1) begin
        d_valid = 1'b1;
        d_data = 8'(77 + dch);
      end
      if (dc != 0) dc--;
      if (rst_n && d_req) begin
        chk("R8 dual channel range", int'(d_ch < 2'd2), 1);
        dch = int'(d_ch);
        dc = 2;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic write_code(input int code);
    @(negedge clk);
    avg_we = 1'b1;
    avg_wdata = 3'(code);
    @(negedge clk);
    avg_we = 1'b0;
  endtask

  task automatic arm(input int a, input int b, input int lim, input bit clear);
    if (clear) for (int c = 0; c < 4; c++) k[c] = 0;
    pa = a; pb = b; plim = lim;
    resp_en = 1'b1;
  endtask

  // run until every channel published; returns mask of channels that pulsed
  task automatic wait_all_pub(output logic [3:0] seen);
    seen = '0;
    for (int t = 0; t < 20000 && seen != 4'hF; t++) begin
      @(negedge clk);
      seen |= upd;
    end
    resp_en = 1'b0;
  endtask

  // run until answered count reached, noting any publication
  task automatic wait_answered(input int lim, output logic [3:0] seen);
    seen = '0;
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      seen |= upd;
      if (k[0] >= lim && k[1] >= lim && k[2] >= lim && k[3] >= lim) break;
    end
    repeat (4) begin
      @(negedge clk);
      seen |= upd;
    end
    resp_en = 1'b0;
  endtask

  initial begin
    logic [3:0] seen;
    logic [3:0] any_upd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 result", int'(result), 0);
    chk("R1 code", int'(avg_code), 4);
    chk("R1 raw_valid", int'(raw_valid), 0);
    chk("R1 upd", int'(upd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 result after release", int'(result), 0);

    // R4 R5 R11: every averaging code
    for (int v = 0; v < 8; v++) begin
      int code;
      code = int'(VEC[v][31:24]);
      write_code(code);
      chk("R5 code held", int'(avg_code), code);
      arm(int'(VEC[v][23:16]), int'(VEC[v][15:8]), 1 << code, 1'b1);
      wait_all_pub(seen);
      chk("R4 all channels published", int'(seen), 15);
      for (int c = 0; c < 4; c++)
        chk((code == 7) ? "R11 full window mean" : "R4 mean",
            int'(result[c*8 +: 8]), int'(VEC[v][7:0]) + c);
    end

    // R7: partial window, then a new code
    write_code(2);
    arm(50, 50, 2, 1'b1);
    wait_answered(2, seen);
    chk("R6 no publication mid-window", int'(seen), 0);
    for (int c = 0; c < 4; c++) chk("R6 previous mean held", int'(result[c*8 +: 8]), 252 + c);
    write_code(1);
    for (int c = 0; c < 4; c++) chk("R7 results kept on restart", int'(result[c*8 +: 8]), 252 + c);
    arm(20, 20, 2, 1'b1);
    wait_all_pub(seen);
    for (int c = 0; c < 4; c++) chk("R7 fresh window only", int'(result[c*8 +: 8]), 20 + c);

    // R10: rewriting the same code keeps partial sums
    arm(60, 62, 1, 1'b1);
    wait_answered(1, seen);
    chk("R10 no early publication", int'(seen), 0);
    write_code(1);
    arm(60, 62, 2, 1'b0);
    wait_all_pub(seen);
    for (int c = 0; c < 4; c++) chk("R10 sum kept", int'(result[c*8 +: 8]), 61 + c);

    // R9: strobe while no request is open (request cycle itself)
    write_code(0);
    @(negedge clk);
    while (!conv_req) @(negedge clk);
    spur_data = 8'hEE;
    spur_valid = 1'b1;
    @(negedge clk);
    spur_valid = 1'b0;
    chk("R9 no raw strobe", int'(raw_valid), 0);
    any_upd = upd;
    repeat (12) begin
      @(negedge clk);
      any_upd |= upd;
    end
    chk("R9 no publication", int'(any_upd), 0);
    for (int c = 0; c < 4; c++) chk("R9 results untouched", int'(result[c*8 +: 8]), 61 + c);

    // R8: two-channel copy, default 16-sample window
    chk("R8 dual ch0", int'(d_result[7:0]), 77);
    chk("R8 dual ch1", int'(d_result[15:8]), 78);
    chk("R8 dual ch2 zero", int'(d_result[23:16]), 0);
    chk("R8 dual ch3 zero", int'(d_result[31:24]), 0);
    chk("R1 dual default code", int'(d_code), 4);

    finish_run();
  end
endmodule